// File: doc/BRIEF.md
# Local-Oscillator Reference and Feedback Divider

This block is the digital divider pair of a channel synthesizer loop. On the crystal side, a counter divides the fixed crystal clock by a reference modulus K. K is one of six fixed values, chosen by a set of rate-select flags, and the result is the comparison reference tick. On the oscillator side, a second counter divides the prescaled VCO feedback clock by a 15-bit channel number N. N is assembled from a low byte and a 7-bit high field.

Both ticks feed a phase comparator outside this block. One enable input gates both dividers. While the enable is low, both dividers sit idle. When it is raised, each divider starts a fresh count. A change of K or N never cuts short a count already in progress: the new value is loaded at the next terminal count.

Each counter runs in its own clock domain. The select flags, N and the enable are treated as quasi-static control inputs.

Top module: `lo_ref_div`

## Requirements
- R1: While rst_ni is low, ref_tick_o and fb_tick_o are low.
- R2: While en_i is low, both ticks stay low. No tick appears on either output, however long the enable stays low.
- R3: rate_sel_i bit 0 selects K=2230, bit 1 selects K=1784, bit 2 selects K=1115, bit 3 selects K=892 and bit 4 selects K=446. With all five bits zero, K=4460.
- R4: When several rate_sel_i bits are set, the highest-numbered set bit decides K.
- R5: In steady state, ref_tick_o is high for exactly one crystal cycle. Its period is exactly K crystal cycles. This holds for any modulus of 2 or more.
- R6: N = {n_hi_i[6:0], n_lo_i[7:0]}. In steady state, fb_tick_o is one feedback cycle wide and repeats every N feedback cycles.
- R7: A change of K or N made during a count does not alter that count. The new modulus governs the period that starts at the next tick.
- R8: Let edge E be the first rising clock edge that samples en_i high after it was low. Each divider loads its modulus M at edge E and raises its tick at the M-th rising edge after E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | Crystal clock, reference divider domain |
| fb_clk_i | input | 1 | Prescaled VCO feedback clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| en_i | input | 1 | Loop divider enable, low holds both counters idle |
| rate_sel_i | input | 5 | Reference rate select flags, higher bit has priority |
| n_lo_i | input | 8 | Feedback modulus bits 7:0 |
| n_hi_i | input | 7 | Feedback modulus bits 14:8 |
| ref_tick_o | output | 1 | One-cycle reference comparison tick |
| fb_tick_o | output | 1 | One-cycle feedback comparison tick |

## Verification
Each single select flag is set in turn, followed by the all-zero pattern. Measuring the period for each one shows that every flag reaches its own modulus and that the default applies only when no flag is set. Patterns with several flags set, including adjacent, sparse and all-ones patterns, separate true top-bit priority from low-bit or OR-combined decoding. Feedback values with and without bits in the high field expose a wrong byte split. A modulus changed right after a tick shows whether the new value is picked up at the terminal count or in the middle of a count. Restarting from disable pins the latency of the first tick.

// File: rtl/lo_div_pkg.sv
package lo_div_pkg;
  localparam int K_W     = 13;
  localparam int RATE_N  = 5;
  localparam int NLO_W   = 8;
  localparam int NHI_W   = 7;
  localparam int N_W     = NLO_W + NHI_W;
  localparam logic [K_W-1:0] K_DEFAULT = K_W'(4460);

  // modulus for rate flag idx; higher idx means faster comparison rate
  function automatic logic [K_W-1:0] rate_k(input int idx);
    case (idx)
      0:       return K_W'(2230);
      1:       return K_W'(1784);
      2:       return K_W'(1115);
      3:       return K_W'(892);
      4:       return K_W'(446);
      default: return K_DEFAULT;
    endcase
  endfunction
endpackage

// File: rtl/lo_rate_sel.sv
module lo_rate_sel
  import lo_div_pkg::*;
(
  input  logic [RATE_N-1:0] sel_i,
  output logic [K_W-1:0]    k_o
);
  // ascending scan: last (highest) set flag wins
  always_comb begin
    k_o = K_DEFAULT;
    for (int i = 0; i < RATE_N; i++) begin
      if (sel_i[i]) k_o = rate_k(i);
    end
  end
endmodule

// File: rtl/lo_div_counter.sv
module lo_div_counter #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] mod_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tick_o <= 1'b0;
    end else if (!run_q) begin
      // first enabled edge: load, no tick
      run_q  <= 1'b1;
      cnt_q  <= mod_i - 1'b1;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      // terminal count: tick and sample modulus afresh
      cnt_q  <= mod_i - 1'b1;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);

  p_tick_needs_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_q);

  p_no_early_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |=> !tick_o);

  p_reload_at_terminal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && cnt_q == '0) |=> (cnt_q == W'($past(mod_i) - 1'b1)));
endmodule

// File: rtl/lo_ref_div.sv
module lo_ref_div
  import lo_div_pkg::*;
(
  input  logic              xtal_clk_i,
  input  logic              fb_clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_N-1:0] rate_sel_i,
  input  logic [NLO_W-1:0]  n_lo_i,
  input  logic [NHI_W-1:0]  n_hi_i,
  output logic              ref_tick_o,
  output logic              fb_tick_o
);
  logic [K_W-1:0] k_mod;
  logic [N_W-1:0] n_mod;

  assign n_mod = {n_hi_i, n_lo_i};

  lo_rate_sel u_rate_sel (
    .sel_i (rate_sel_i),
    .k_o   (k_mod)
  );

  lo_div_counter #(.W(K_W)) u_ref_cnt (
    .clk_i  (xtal_clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mod_i  (k_mod),
    .tick_o (ref_tick_o)
  );

  lo_div_counter #(.W(N_W)) u_fb_cnt (
    .clk_i  (fb_clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mod_i  (n_mod),
    .tick_o (fb_tick_o)
  );
endmodule

// File: tb/lo_ref_div_tb_top.sv
module lo_ref_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FB_PERIOD  = 14;
  localparam int WDOG_LIMIT = 190000;

  logic       xclk = 1'b0;
  logic       fclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] sel = '0;
  logic [7:0] n_lo = '0;
  logic [6:0] n_hi = '0;
  logic       ref_tick, fb_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) xclk = ~xclk;
  always #(FB_PERIOD/2)  fclk = ~fclk;

  lo_ref_div dut_i (
    .xtal_clk_i (xclk),
    .fb_clk_i   (fclk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .rate_sel_i (sel),
    .n_lo_i     (n_lo),
    .n_hi_i     (n_hi),
    .ref_tick_o (ref_tick),
    .fb_tick_o  (fb_tick)
  );

  always @(posedge xclk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic xgap(output int g);
    g = 0;
    do begin @(negedge xclk); g++; end while (!ref_tick);
  endtask

  task automatic fgap(output int g);
    g = 0;
    do begin @(negedge fclk); g++; end while (!fb_tick);
  endtask

  task automatic set_n(input int n);
    n_lo = n[7:0];
    n_hi = n[14:8];
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge xclk);
      if (ref_tick || fb_tick) bad++;
    end
    check(bad == 0, "R1 ticks low in reset", bad, 0);
    @(negedge xclk);
    rst_n = 1'b1;
  endtask

  task automatic t_ref_start();
    int g;
    sel = 5'b10000;
    @(negedge xclk);
    en = 1'b1;
    xgap(g);
    check(g == 447, "R8 first ref tick latency", g, 447);
    xgap(g);
    check(g == 446, "R5 ref period K=446", g, 446);
    @(negedge xclk);
    check(!ref_tick, "R5 ref tick one cycle wide", ref_tick, 0);
  endtask

  task automatic t_ref_rate(input logic [4:0] s, input int exp, input string tag);
    int g;
    sel = s;
    xgap(g);
    xgap(g);
    check(g == exp, tag, g, exp);
  endtask

  task automatic t_ref_midchange();
    int g;
    sel = 5'b10000;
    xgap(g);
    xgap(g);
    sel = 5'b00000;
    xgap(g);
    check(g == 446, "R7 running ref count keeps old K", g, 446);
    xgap(g);
    check(g == 4460, "R7 new K after terminal count", g, 4460);
  endtask

  task automatic t_fb_period(input int n, input string tag);
    int g;
    set_n(n);
    fgap(g);
    fgap(g);
    check(g == n, tag, g, n);
  endtask

  task automatic t_fb_width_and_change();
    int g;
    set_n(3);
    fgap(g);
    fgap(g);
    @(negedge fclk);
    check(!fb_tick, "R6 fb tick one cycle wide", fb_tick, 0);
    set_n(5);
    fgap(g);
    check(g == 2, "R7 running fb count keeps old N", g, 2);
    fgap(g);
    check(g == 5, "R7 new N after terminal count", g, 5);
  endtask

  task automatic t_fb_start();
    int g;
    set_n(7);
    @(negedge fclk);
    en = 1'b0;
    repeat (10) @(negedge fclk);
    en = 1'b1;
    fgap(g);
    check(g == 8, "R8 first fb tick latency", g, 8);
  endtask

  task automatic t_disable();
    int rb = 0;
    int fb = 0;
    set_n(3);
    sel = 5'b10000;
    @(negedge xclk);
    en = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge xclk);
      if (ref_tick) rb++;
    end
    for (int i = 0; i < 500; i++) begin
      @(negedge fclk);
      if (fb_tick) fb++;
    end
    check(rb == 0, "R2 no ref tick while disabled", rb, 0);
    check(fb == 0, "R2 no fb tick while disabled", fb, 0);
  endtask

  initial begin
    t_reset();
    t_ref_start();
    t_ref_rate(5'b00001, 2230, "R3 flag0 K=2230");
    t_ref_rate(5'b00010, 1784, "R3 flag1 K=1784");
    t_ref_rate(5'b00100, 1115, "R3 flag2 K=1115");
    t_ref_rate(5'b01000, 892,  "R3 flag3 K=892");
    t_ref_rate(5'b10000, 446,  "R3 flag4 K=446");
    t_ref_rate(5'b00000, 4460, "R3 default K=4460");
    t_ref_rate(5'b00011, 1784, "R4 flags 1,0 give K=1784");
    t_ref_rate(5'b10101, 446,  "R4 flags 4,2,0 give K=446");
    t_ref_rate(5'b01100, 892,  "R4 flags 3,2 give K=892");
    t_ref_rate(5'b11111, 446,  "R4 all flags give K=446");
    t_ref_midchange();
    t_fb_period(4898,  "R6 N=4898 split bytes");
    t_fb_period(11534, "R6 N=11534 high field");
    t_fb_period(200,   "R6 N=200 low byte only");
    t_fb_width_and_change();
    t_fb_start();
    t_disable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule